// File: doc/BRIEF.md
# Capture/Compare Event Flag Register

This block keeps the sticky status flags of a multi-channel timer. Each channel has one flag that goes high when the timer reports an input-capture or output-compare event on that channel. A separate flag goes high when the timer counter overflows. Software reads the flags through a small byte-wide register port and clears them by writing ones. Each flag also drives its own level-sensitive interrupt request.

A fast-clear mode removes the need for an explicit clear write. When it is enabled, the access that software makes anyway clears the flag. Reading a channel's capture data clears that channel's flag, and so does writing its compare data. A read of the counter clears the overflow flag. The capture/compare datapath supplies these access strobes as single-cycle pulses. Masking of the requests is done downstream.

Top module: `evtflag_unit`

## Requirements
- R1: After reset both registers read 0x00, and all flag and request outputs are low.
- R2: A one-cycle pulse on `chan_evt[i]` sets channel flag i at the next clock edge. The flag reads back in bit i of the channel register at address 0.
- R3: A write to address 0 clears every channel flag whose data bit is 1 and leaves flags written with 0 unchanged. Reads never change a flag.
- R4: In the channel register, bits 7 down to NUM_CH read as zero. In the overflow register at address 1, bits 6 to 0 read as zero. Writing ones to these bits changes no flag.
- R5: While `fast_clr_en` is 1, a pulse on `cap_rd[i]` or `cmp_wr[i]` clears channel flag i only. While `fast_clr_en` is 0, these strobes have no effect.
- R6: If a set event and any clear (a write or a fast clear) hit the same flag in the same cycle, the flag is 1 after that edge.
- R7: A flag that is already set stays set on further events. After it has been cleared, a new event sets it again.
- R8: A pulse on `ovf_evt` sets the overflow flag, which reads back in bit 7 of address 1. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R9: While `fast_clr_en` is 1, a pulse on `cnt_rd` clears the overflow flag. While `fast_clr_en` is 0, it has no effect.
- R10: `chan_irq[i]` and `ovf_irq` are high exactly while the matching flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register select: 0 channel flags, 1 overflow flag |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Read data of the addressed register |
| chan_evt | input | NUM_CH | Per-channel capture/compare event pulses |
| ovf_evt | input | 1 | Counter overflow pulse |
| fast_clr_en | input | 1 | Enables clearing by data access |
| cap_rd | input | NUM_CH | Capture data read strobes |
| cmp_wr | input | NUM_CH | Compare data write strobes |
| cnt_rd | input | 1 | Counter read strobe |
| chan_flag | output | NUM_CH | Channel flag values |
| ovf_flag | output | 1 | Overflow flag value |
| chan_irq | output | NUM_CH | Per-channel level interrupt requests |
| ovf_irq | output | 1 | Overflow level interrupt request |

## Verification
The assertions are checked on every cycle. They cover the rules of each flag cell: a set event wins over a clear, a clear with no set drops the flag, and a flag with no request holds its value. They also check that reserved read bits stay zero and that the data-access strobes cannot touch a flag while fast clear is off. Only the bench scenarios can show the register-level mapping: which bit a write clears, that a fast clear on one channel leaves its neighbours set, that reads have no side effect, and how the overflow flag behaves at its own address.

// File: rtl/evtflag_pkg.sv
package evtflag_pkg;
   localparam int unsigned REG_W = 8;
   typedef logic [REG_W-1:0] reg_byte_t;
   localparam int unsigned CH_REG_ADDR  = 0;
   localparam int unsigned OVF_REG_ADDR = 1;
   localparam int unsigned OVF_BIT      = REG_W - 1;
endpackage

// File: rtl/evtflag_cell.sv
module evtflag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic q;

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b0;
      else if (set_i)  q <= 1'b1;
      else if (clr_i)  q <= 1'b0;
   end

   assign flag_o = q;

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/evtflag_fastclr.sv
module evtflag_fastclr #(
   parameter int unsigned NUM_CH       = 4,
   parameter bit          OVF_FAST_CLR = 1'b1
) (
   input  logic              fast_clr_en,
   input  logic [NUM_CH-1:0] cap_rd,
   input  logic [NUM_CH-1:0] cmp_wr,
   input  logic              cnt_rd,
   output logic [NUM_CH-1:0] chan_fclr,
   output logic              ovf_fclr
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign chan_fclr[i] = fast_clr_en & (cap_rd[i] | cmp_wr[i]);
   end

   if (OVF_FAST_CLR) begin : g_ovf_on
      assign ovf_fclr = fast_clr_en & cnt_rd;
   end else begin : g_ovf_off
      assign ovf_fclr = 1'b0;
      logic unused_cnt_rd;
      assign unused_cnt_rd = cnt_rd;
   end
endmodule

// File: rtl/evtflag_regif.sv
module evtflag_regif
   import evtflag_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  reg_byte_t         bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [NUM_CH-1:0] chan_q,
   input  logic              ovf_q,
   output logic [NUM_CH-1:0] chan_wclr,
   output logic              ovf_wclr,
   output reg_byte_t         bus_rdata
);
   localparam logic [ADDR_W-1:0] CH_SEL  = ADDR_W'(CH_REG_ADDR);
   localparam logic [ADDR_W-1:0] OVF_SEL = ADDR_W'(OVF_REG_ADDR);

   logic hit_ch, hit_ovf;
   assign hit_ch  = (bus_addr == CH_SEL);
   assign hit_ovf = (bus_addr == OVF_SEL);

   assign chan_wclr = (bus_wr && hit_ch) ? bus_wdata[NUM_CH-1:0] : '0;
   assign ovf_wclr  = bus_wr && hit_ovf && bus_wdata[OVF_BIT];

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (hit_ch)       bus_rdata[NUM_CH-1:0] = chan_q;
         else if (hit_ovf) bus_rdata[OVF_BIT]    = ovf_q;
      end
   end

   assert_ch_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_ch) |-> (bus_rdata[REG_W-1:NUM_CH] == '0));
   assert_ovf_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_ovf) |-> (bus_rdata[OVF_BIT-1:0] == '0));
endmodule

// File: rtl/evtflag_unit.sv
module evtflag_unit
   import evtflag_pkg::*;
#(
   parameter int unsigned NUM_CH       = 4,
   parameter int unsigned ADDR_W       = 1,
   parameter bit          OVF_FAST_CLR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic [NUM_CH-1:0] chan_evt,
   input  logic              ovf_evt,
   input  logic              fast_clr_en,
   input  logic [NUM_CH-1:0] cap_rd,
   input  logic [NUM_CH-1:0] cmp_wr,
   input  logic              cnt_rd,
   output logic [NUM_CH-1:0] chan_flag,
   output logic              ovf_flag,
   output logic [NUM_CH-1:0] chan_irq,
   output logic              ovf_irq
);
   if (NUM_CH < 1 || NUM_CH > REG_W - 1) begin : g_bad_ch
      $error("NUM_CH must leave the overflow bit position free");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic [NUM_CH-1:0] chan_wclr, chan_fclr;
   logic              ovf_wclr, ovf_fclr;

   evtflag_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .chan_q    (chan_flag),
      .ovf_q     (ovf_flag),
      .chan_wclr (chan_wclr),
      .ovf_wclr  (ovf_wclr),
      .bus_rdata (bus_rdata)
   );

   evtflag_fastclr #(.NUM_CH(NUM_CH), .OVF_FAST_CLR(OVF_FAST_CLR)) u_fastclr (
      .fast_clr_en (fast_clr_en),
      .cap_rd      (cap_rd),
      .cmp_wr      (cmp_wr),
      .cnt_rd      (cnt_rd),
      .chan_fclr   (chan_fclr),
      .ovf_fclr    (ovf_fclr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      evtflag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (chan_evt[i]),
         .clr_i  (chan_wclr[i] | chan_fclr[i]),
         .flag_o (chan_flag[i])
      );

      assert_fastclr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!fast_clr_en && !(bus_wr && bus_addr == ADDR_W'(CH_REG_ADDR) && bus_wdata[i])
          && chan_flag[i]) |=> chan_flag[i]);
   end

   evtflag_cell u_ovf_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ovf_evt),
      .clr_i  (ovf_wclr | ovf_fclr),
      .flag_o (ovf_flag)
   );

   assign chan_irq = chan_flag;
   assign ovf_irq  = ovf_flag;

   assert_cnt_rd_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_clr_en && !bus_wr && ovf_flag) |=> ovf_flag);
endmodule

// File: tb/evtflag_unit_tb.sv
module evtflag_unit_tb;
   localparam int CLK_P = 10;
   localparam int NCH   = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [0:0]     bus_addr;
   logic [7:0]     bus_wdata, bus_rdata;
   logic           bus_wr, bus_rd;
   logic [NCH-1:0] chan_evt, cap_rd, cmp_wr, chan_flag, chan_irq;
   logic           ovf_evt, fast_clr_en, cnt_rd, ovf_flag, ovf_irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   evtflag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .chan_evt(chan_evt), .ovf_evt(ovf_evt), .fast_clr_en(fast_clr_en),
      .cap_rd(cap_rd), .cmp_wr(cmp_wr), .cnt_rd(cnt_rd),
      .chan_flag(chan_flag), .ovf_flag(ovf_flag),
      .chan_irq(chan_irq), .ovf_irq(ovf_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      bus_wr = 0; bus_rd = 0; chan_evt = '0; ovf_evt = 0;
      cap_rd = '0; cmp_wr = '0; cnt_rd = 0;
   endtask

   task automatic rd(input logic [0:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [0:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step(); idle();
   endtask

   task automatic pulse_evt(input logic [NCH-1:0] m);
      chan_evt = m; step(); idle();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, d); chk("R1 chan reg", d, 8'h00);
      rd(1'b1, d); chk("R1 ovf reg", d, 8'h00);
      chk("R1 irq outputs", {3'b0, ovf_irq, chan_irq}, 8'h00);
   endtask

   task automatic t_set();
      logic [7:0] d;
      pulse_evt(4'b0101);
      rd(1'b0, d); chk("R2 event sets flags", d, 8'h05);
      chk("R10 chan irq follows", {4'b0, chan_irq}, 8'h05);
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      wr(1'b0, 8'h01);
      rd(1'b0, d); chk("R3 write one clears", d, 8'h04);
      wr(1'b0, 8'h00);
      rd(1'b0, d); chk("R3 write zero keeps", d, 8'h04);
      rd(1'b0, d); chk("R3 read no side effect", d, 8'h04);
      chk("R10 irq drops with flag", {4'b0, chan_irq}, 8'h04);
   endtask

   task automatic t_reserved();
      logic [7:0] d;
      wr(1'b0, 8'hF0);
      rd(1'b0, d); chk("R4 reserved write ignored", d, 8'h04);
      wr(1'b1, 8'h7F);
      rd(1'b1, d); chk("R4 ovf reg reserved zero", d, 8'h00);
      rd(1'b0, d); chk("R4 chan unaffected", d, 8'h04);
   endtask

   task automatic t_fast();
      logic [7:0] d;
      pulse_evt(4'hF);
      fast_clr_en = 0; cap_rd = 4'b0010; cmp_wr = 4'b1000; step(); idle();
      rd(1'b0, d); chk("R5 strobes ignored when off", d, 8'h0F);
      fast_clr_en = 1; cap_rd = 4'b0010; step(); idle();
      rd(1'b0, d); chk("R5 capture read clears one", d, 8'h0D);
      cmp_wr = 4'b1000; step(); idle();
      rd(1'b0, d); chk("R5 compare write clears one", d, 8'h05);
      fast_clr_en = 0;
   endtask

   task automatic t_prio();
      logic [7:0] d;
      bus_addr = 1'b0; bus_wdata = 8'h01; bus_wr = 1; chan_evt = 4'b0001;
      step(); idle();
      rd(1'b0, d); chk("R6 set beats write clear", d, 8'h05);
      fast_clr_en = 1; cap_rd = 4'b0100; chan_evt = 4'b0100; step(); idle();
      fast_clr_en = 0;
      rd(1'b0, d); chk("R6 set beats fast clear", d, 8'h05);
   endtask

   task automatic t_repeat();
      logic [7:0] d;
      pulse_evt(4'b0100);
      rd(1'b0, d); chk("R7 repeat event keeps set", d, 8'h05);
      wr(1'b0, 8'h04);
      rd(1'b0, d); chk("R7 cleared", d, 8'h01);
      pulse_evt(4'b0100);
      rd(1'b0, d); chk("R7 event after clear sets", d, 8'h05);
   endtask

   task automatic t_ovf();
      logic [7:0] d;
      ovf_evt = 1; step(); idle();
      rd(1'b1, d); chk("R8 overflow sets bit7", d, 8'h80);
      chk("R10 ovf irq", {7'b0, ovf_irq}, 8'h01);
      wr(1'b1, 8'h7F);
      rd(1'b1, d); chk("R8 write zero keeps", d, 8'h80);
      wr(1'b1, 8'h80);
      rd(1'b1, d); chk("R8 write one clears", d, 8'h00);
      ovf_evt = 1; step(); idle();
      fast_clr_en = 0; cnt_rd = 1; step(); idle();
      rd(1'b1, d); chk("R9 counter read ignored when off", d, 8'h80);
      fast_clr_en = 1; cnt_rd = 1; ovf_evt = 1; step(); idle();
      rd(1'b1, d); chk("R6 overflow set beats fast clear", d, 8'h80);
      cnt_rd = 1; step(); idle();
      rd(1'b1, d); chk("R9 counter read clears", d, 8'h00);
      rd(1'b0, d); chk("R9 channel flags untouched", d, 8'h05);
      fast_clr_en = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0; bus_addr = 0; bus_wdata = 0; fast_clr_en = 0;
      idle();
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_set();
      t_w1c();
      t_reserved();
      t_fast();
      t_prio();
      t_repeat();
      t_ovf();
      step();
      finish_run();
   end
endmodule